// File: doc/BRIEF.md
# Instruction Prefetch Queue and Bus Status Encoder

This block sits between a simple CPU core and its external bus. It keeps a small queue of instruction words filled ahead of the core. On every cycle it places a 4-bit status code on the bus that says why the bus is busy, or why it is idle. The core's own accesses go first: operand reads and writes, the two halves of a read-modify-write, effective-address reads, and the interrupt acknowledge and end-of-interrupt reads. Whenever no such access is waiting and the queue has room, the block issues an instruction fetch from its own fetch pointer.

A control-flow change (jump, branch, interrupt or trap) reaches the block as a purge pulse with a new target address. The purge empties the queue and reloads the fetch pointer in the same cycle. A fetch that is still on the bus when the purge arrives is allowed to finish, but its data is thrown away. The first fetch after a purge, or after reset, carries the non-sequential code. Only one bus cycle is open at a time, and it ends on a ready input from the bus.

Top module: `fetch_status_ctl`

## Requirements
- R1: While no bus cycle is open, `bus_status` gives the idle reason: 0011 when `slave_wait` is high, otherwise 0001 when `wait_instr` is high, otherwise 0000. All idle codes have bits 3 and 2 at zero.
- R2: An instruction fetch starts on a clock edge where the bus is free, `acc_req` is low, `purge` is low and the queue will have room after that edge. A sequential fetch shows code 1000, and each fetch address is 2 above the previous one.
- R3: The first fetch after reset, or after a purge, shows code 1001 at the new start address.
- R4: `acc_kind` selects the status of a core access. 0 = data transfer, 1010. 1 = read half of a read-modify-write, 1011. 2 = its write half, 1010. 3 = effective-address read, 1100. 4 = interrupt acknowledge master, 0100. 5 = interrupt acknowledge cascaded, 0101. 6 = end-of-interrupt master, 0110. 7 = end-of-interrupt cascaded, 0111. The access is driven on `bus_addr` from `acc_addr`.
- R5: When a core access and a fetch could both start on the same edge, the access wins. `acc_gnt` is high in the cycle before the edge on which the access starts.
- R6: Only one bus cycle is open at a time. Its status and address stay unchanged until a cycle in which `bus_rdy` is high. `acc_done` is high in the completing cycle of a core access and low for fetches.
- R7: The queue holds up to 4 sixteen-bit words in fetch order. `q_valid` shows that `q_data` holds the oldest word, and `q_pop` removes that word. No fetch starts if the words in the queue plus any fetch still on the bus would fill it beyond 4.
- R8: `purge` empties the queue on that edge and loads `purge_addr` as the next fetch address. A fetch that is open on the bus during the purge, including one that completes on the purge edge itself, does not write its data into the queue.
- R9: After reset, no bus cycle is open, the queue is empty, and the first fetch goes to the parameter `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Core access request, held until granted |
| acc_kind | input | 3 | Kind of core access (see R4) |
| acc_addr | input | ADDR_W | Address of the core access |
| acc_gnt | output | 1 | Core access starts on the coming edge |
| acc_done | output | 1 | Core access completes in this cycle |
| purge | input | 1 | Control-flow change: empty the queue and restart fetching |
| purge_addr | input | ADDR_W | New fetch address that goes with a purge |
| wait_instr | input | 1 | Core is executing a wait instruction |
| slave_wait | input | 1 | Core is waiting for a slave processor |
| bus_active | output | 1 | A bus cycle is open |
| bus_rdy | input | 1 | Bus completes the open cycle |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_addr | output | ADDR_W | Address of the open bus cycle |
| bus_status | output | 4 | Status code of this cycle |
| q_pop | input | 1 | Remove the oldest queued word |
| q_valid | output | 1 | Queue is not empty |
| q_data | output | DATA_W | Oldest queued word |

## Verification
Two pairs of events can fall on the same clock edge. First, a core access request can arrive on the very edge where a queue pop has just made room for a fetch. The bench raises `acc_req` and `q_pop` together, and the scoreboard must then see the access complete before the fetch. Second, a purge can land on the edge where a fetch completes with `bus_rdy` high. The bench pops one word to start a fetch and raises `purge` in the very next cycle, so the fetch completes on the purge edge. The bench then checks that the first word read from the refilled queue comes from the new address and not from the discarded fetch. A purge against a fetch held open by wait states is also checked, along with the non-sequential code that follows it.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;

    // core access kinds, encoded as on the acc_kind port
    typedef enum logic [2:0] {
        AK_DATA   = 3'd0,
        AK_RMW_RD = 3'd1,
        AK_RMW_WR = 3'd2,
        AK_EA     = 3'd3,
        AK_IACK_M = 3'd4,
        AK_IACK_C = 3'd5,
        AK_EOI_M  = 3'd6,
        AK_EOI_C  = 3'd7
    } acc_kind_e;

    // bus status codes, bit 0 least significant
    typedef enum logic [3:0] {
        ST_IDLE   = 4'b0000,
        ST_WAITI  = 4'b0001,
        ST_SLAVE  = 4'b0011,
        ST_IACK_M = 4'b0100,
        ST_IACK_C = 4'b0101,
        ST_EOI_M  = 4'b0110,
        ST_EOI_C  = 4'b0111,
        ST_SEQ    = 4'b1000,
        ST_NSEQ   = 4'b1001,
        ST_DATA   = 4'b1010,
        ST_RMW    = 4'b1011,
        ST_EA     = 4'b1100
    } bus_st_e;

    typedef enum logic [1:0] {
        ISS_NONE  = 2'd0,
        ISS_ACC   = 2'd1,
        ISS_FETCH = 2'd2
    } issue_e;

    // descriptor of the bus cycle that is open
    typedef struct packed {
        logic    busy;
        logic    fetch;
        logic    stale;
        bus_st_e code;
    } cyc_t;

    function automatic bus_st_e acc_code(acc_kind_e k);
        case (k)
            AK_DATA:   return ST_DATA;
            AK_RMW_RD: return ST_RMW;
            AK_RMW_WR: return ST_DATA;
            AK_EA:     return ST_EA;
            AK_IACK_M: return ST_IACK_M;
            AK_IACK_C: return ST_IACK_C;
            AK_EOI_M:  return ST_EOI_M;
            default:   return ST_EOI_C;
        endcase
    endfunction

    function automatic bus_st_e idle_code(logic slave, logic waiti);
        if (slave) return ST_SLAVE;
        if (waiti) return ST_WAITI;
        return ST_IDLE;
    endfunction

endpackage

// File: rtl/fsc_fetch_queue.sv
`timescale 1ns/1ps
module fsc_fetch_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          valid,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          pop_ok, push_ok;

    assign valid   = (count != '0);
    assign rdata   = mem[rd_ptr];
    assign pop_ok  = pop && valid && !flush;
    assign push_ok = push && !flush;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R7
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        push_ok |-> (count < CW'(DEPTH)) || pop_ok);

endmodule

// File: rtl/fsc_issue_arb.sv
`timescale 1ns/1ps
module fsc_issue_arb
    import fsc_pkg::*;
(
    input  logic   free,
    input  logic   acc_req,
    input  logic   purge,
    input  logic   room,
    output issue_e iss
);
    always_comb begin
        iss = ISS_NONE;
        if (free) begin
            if (acc_req)             iss = ISS_ACC;
            else if (!purge && room) iss = ISS_FETCH;
        end
    end
endmodule

// File: rtl/fetch_status_ctl.sv
`timescale 1ns/1ps
module fetch_status_ctl
    import fsc_pkg::*;
#(
    parameter int ADDR_W                  = 24,
    parameter int DATA_W                  = 16,
    parameter int Q_DEPTH                 = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_req,
    input  logic [2:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_gnt,
    output logic              acc_done,
    input  logic              purge,
    input  logic [ADDR_W-1:0] purge_addr,
    input  logic              wait_instr,
    input  logic              slave_wait,
    output logic              bus_active,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_status,
    input  logic              q_pop,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data
);
    localparam int CW = $clog2(Q_DEPTH + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    cyc_t              cyc;
    logic [ADDR_W-1:0] cyc_addr, fetch_ptr;
    logic              nseq_next;

    logic              done, free, keep, pop_eff, room;
    logic [CW-1:0]     q_count;
    logic [CW:0]       occ_after;
    issue_e            iss;

    assign done    = cyc.busy && bus_rdy;
    assign free    = !cyc.busy || bus_rdy;
    assign keep    = done && cyc.fetch && !cyc.stale && !purge;
    assign pop_eff = q_pop && q_valid && !purge;

    // occupancy after this edge, counting a completing fetch that is kept
    assign occ_after = {1'b0, q_count} + (CW+1)'(keep) - (CW+1)'(pop_eff);
    assign room      = occ_after < (CW+1)'(Q_DEPTH);

    fsc_issue_arb u_arb (
        .free    (free),
        .acc_req (acc_req),
        .purge   (purge),
        .room    (room),
        .iss     (iss)
    );

    fsc_fetch_queue #(.DEPTH(Q_DEPTH), .W(DATA_W)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (purge),
        .push  (keep),
        .wdata (bus_rdata),
        .pop   (q_pop),
        .rdata (q_data),
        .valid (q_valid),
        .count (q_count)
    );

    assign acc_gnt    = (iss == ISS_ACC);
    assign acc_done   = done && !cyc.fetch;
    assign bus_active = cyc.busy;
    assign bus_addr   = cyc_addr;
    assign bus_status = cyc.busy ? cyc.code : idle_code(slave_wait, wait_instr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc       <= '{busy: 1'b0, fetch: 1'b0, stale: 1'b0, code: ST_IDLE};
            cyc_addr  <= '0;
            fetch_ptr <= RESET_ADDR;
            nseq_next <= 1'b1;
        end else begin
            if (done) begin
                cyc.busy  <= 1'b0;
                cyc.stale <= 1'b0;
            end else if (purge && cyc.busy && cyc.fetch) begin
                cyc.stale <= 1'b1;
            end
            case (iss)
                ISS_ACC: begin
                    cyc.busy  <= 1'b1;
                    cyc.fetch <= 1'b0;
                    cyc.code  <= acc_code(acc_kind_e'(acc_kind));
                    cyc_addr  <= acc_addr;
                end
                ISS_FETCH: begin
                    cyc.busy  <= 1'b1;
                    cyc.fetch <= 1'b1;
                    cyc.code  <= nseq_next ? ST_NSEQ : ST_SEQ;
                    cyc_addr  <= fetch_ptr;
                    fetch_ptr <= fetch_ptr + STEP;
                    nseq_next <= 1'b0;
                end
                default: ;
            endcase
            if (purge) begin
                fetch_ptr <= purge_addr;
                nseq_next <= 1'b1;
            end
        end
    end

    // R6
    hold_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !bus_rdy) |=> bus_active && $stable(bus_status) && $stable(bus_addr));

    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> bus_status[3:2] == 2'b00);

    // R8
    purge_empty_chk: assert property (@(posedge clk) disable iff (rst)
        purge |=> !q_valid);

    // R5
    gnt_opens_chk: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |=> bus_active && !$stable(bus_addr) || bus_addr == $past(acc_addr));

endmodule

// File: tb/fetch_status_ctl_bench.sv
`timescale 1ns/1ps
module fetch_status_ctl_bench;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam logic [AW-1:0] RST_A = 24'h000100;

    typedef struct {
        logic [3:0]    st;
        logic [AW-1:0] addr;
        logic          is_acc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_req = 1'b0;
    logic [2:0]    acc_kind = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_gnt, acc_done;
    logic          purge = 1'b0;
    logic [AW-1:0] purge_addr = '0;
    logic          wait_instr = 1'b0, slave_wait = 1'b0;
    logic          bus_active;
    logic          bus_rdy = 1'b1;
    logic [DW-1:0] bus_rdata;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_status;
    logic          q_pop = 1'b0;
    logic          q_valid;
    logic [DW-1:0] q_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];
    logic [AW-1:0] nxt_fa;

    always #10 clk = ~clk; // 50 MHz

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction
    assign bus_rdata = mem_word(bus_addr);

    fetch_status_ctl #(.ADDR_W(AW), .DATA_W(DW), .Q_DEPTH(4), .RESET_ADDR(RST_A)) u_fetch_status_ctl (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_gnt(acc_gnt), .acc_done(acc_done), .purge(purge), .purge_addr(purge_addr),
        .wait_instr(wait_instr), .slave_wait(slave_wait), .bus_active(bus_active),
        .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_status(bus_status),
        .q_pop(q_pop), .q_valid(q_valid), .q_data(q_data)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] kind_code(int k);
        case (k)
            0: return 4'b1010;
            1: return 4'b1011;
            2: return 4'b1010;
            3: return 4'b1100;
            4: return 4'b0100;
            5: return 4'b0101;
            6: return 4'b0110;
            default: return 4'b0111;
        endcase
    endfunction

    task automatic expect_cyc(logic [3:0] st, logic [AW-1:0] a, logic is_acc, string tag);
        exp_t e;
        e.st = st; e.addr = a; e.is_acc = is_acc; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // inputs change 2 ns after a rising edge
    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // monitor: compare every completing bus cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_active && bus_rdy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected bus cycle", {bus_status, 4'h0, bus_addr}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(bus_status == e.st, {e.tag, " status"}, 32'(bus_status), 32'(e.st));
                chk(bus_addr == e.addr, {e.tag, " address"}, 32'(bus_addr), 32'(e.addr));
                chk(acc_done == e.is_acc, "R6 acc_done", 32'(acc_done), 32'(e.is_acc));
            end
        end
    end

    task automatic do_access(int k, logic [AW-1:0] a);
        acc_req  = 1'b1;
        acc_kind = 3'(k);
        acc_addr = a;
        #1;
        while (!acc_gnt) step();
        step();
        acc_req = 1'b0;
    endtask

    task automatic pop_check(logic [AW-1:0] word_addr, string tag);
        chk(q_valid && q_data == mem_word(word_addr), tag, 32'(q_data), 32'(mem_word(word_addr)));
        q_pop = 1'b1;
        expect_cyc(4'b1000, nxt_fa, 1'b0, "R2 refill fetch");
        nxt_fa = nxt_fa + 24'd2;
        step();
        q_pop = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(!bus_active, "R9 no cycle after reset", 32'(bus_active), 32'h0);
        chk(!q_valid, "R9 queue empty after reset", 32'(q_valid), 32'h0);
        chk(bus_status == 4'b0000, "R9 idle status", 32'(bus_status), 32'h0);
        expect_cyc(4'b1001, RST_A, 1'b0, "R3 first fetch after reset");
        expect_cyc(4'b1000, RST_A + 24'd2, 1'b0, "R2 seq fetch");
        expect_cyc(4'b1000, RST_A + 24'd4, 1'b0, "R2 seq fetch");
        expect_cyc(4'b1000, RST_A + 24'd6, 1'b0, "R2 seq fetch");
        nxt_fa = RST_A + 24'd8;
        step(8);

        // R7 queue full: no more fetches
        chk(!bus_active, "R7 no fetch when full", 32'(bus_active), 32'h0);
        chk(exp_q.size() == 0, "R2 fill fetches done", 32'(exp_q.size()), 32'h0);
        // R1 idle reasons
        chk(bus_status == 4'b0000, "R1 idle none", 32'(bus_status), 32'h0);
        wait_instr = 1'b1; #1;
        chk(bus_status == 4'b0001, "R1 idle wait instr", 32'(bus_status), 32'h1);
        slave_wait = 1'b1; #1;
        chk(bus_status == 4'b0011, "R1 idle slave wins", 32'(bus_status), 32'h3);
        wait_instr = 1'b0; #1;
        chk(bus_status == 4'b0011, "R1 idle slave", 32'(bus_status), 32'h3);
        slave_wait = 1'b0;

        // R4 every access kind, back to back
        for (int k = 0; k < 8; k++) begin
            expect_cyc(kind_code(k), 24'h008000 + 24'(k * 4), 1'b1, "R4 access code");
            do_access(k, 24'h008000 + 24'(k * 4));
        end
        step(4);
        chk(exp_q.size() == 0, "R4 all accesses seen", 32'(exp_q.size()), 32'h0);

        // R8 purge while a fetch is held by wait states
        bus_rdy = 1'b0;
        chk(q_data == mem_word(RST_A), "R7 oldest word first", 32'(q_data), 32'(mem_word(RST_A)));
        q_pop = 1'b1;
        expect_cyc(4'b1000, nxt_fa, 1'b0, "R8 stale fetch still completes");
        step();
        q_pop = 1'b0;
        step(2);
        chk(bus_active && bus_status == 4'b1000, "R6 status held", 32'(bus_status), 32'h8);
        chk(bus_addr == nxt_fa, "R6 address held", 32'(bus_addr), 32'(nxt_fa));
        purge = 1'b1;
        purge_addr = 24'h000400;
        step();
        purge = 1'b0;
        #1;
        chk(!q_valid, "R8 purge empties queue", 32'(q_valid), 32'h0);
        expect_cyc(4'b1001, 24'h000400, 1'b0, "R3 first fetch after purge");
        expect_cyc(4'b1000, 24'h000402, 1'b0, "R2 seq after purge");
        expect_cyc(4'b1000, 24'h000404, 1'b0, "R2 seq after purge");
        expect_cyc(4'b1000, 24'h000406, 1'b0, "R2 seq after purge");
        nxt_fa = 24'h000408;
        bus_rdy = 1'b1;
        step(8);
        pop_check(24'h000400, "R8 stale data discarded");
        pop_check(24'h000402, "R7 fifo order");
        pop_check(24'h000404, "R7 fifo order");
        pop_check(24'h000406, "R7 fifo order");
        step(6);

        // R5 access and fetch contend on one edge
        acc_req  = 1'b1;
        acc_kind = 3'd3;
        acc_addr = 24'h009000;
        chk(q_data == mem_word(24'h000408), "R7 word after refill", 32'(q_data), 32'(mem_word(24'h000408)));
        q_pop = 1'b1;
        expect_cyc(4'b1100, 24'h009000, 1'b1, "R5 access before fetch");
        expect_cyc(4'b1000, nxt_fa, 1'b0, "R5 fetch after access");
        nxt_fa = nxt_fa + 24'd2;
        #1;
        chk(acc_gnt, "R5 grant over fetch", 32'(acc_gnt), 32'h1);
        step();
        acc_req = 1'b0;
        q_pop = 1'b0;
        step(5);

        // R8 purge on the edge a fetch completes
        pop_check(24'h00040A, "R7 fifo order");
        purge = 1'b1;
        purge_addr = 24'h000600;
        step();
        purge = 1'b0;
        expect_cyc(4'b1001, 24'h000600, 1'b0, "R3 nonseq after purge");
        expect_cyc(4'b1000, 24'h000602, 1'b0, "R2 seq");
        expect_cyc(4'b1000, 24'h000604, 1'b0, "R2 seq");
        expect_cyc(4'b1000, 24'h000606, 1'b0, "R2 seq");
        nxt_fa = 24'h000608;
        step(8);
        pop_check(24'h000600, "R8 completing fetch discarded");
        step(6);
        chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule